// File: doc/BRIEF.md
# Outstanding-operation wait counter

This block keeps a running count of in-flight operations in three classes: vector memory, export writes, and local/global/constant memory. Each class has its own issue pulse, which raises its counter, and its own completion pulse, which lowers it. The counters saturate at both ends, so a stray pulse cannot wrap them.

A wait request arrives on a strobe together with a 7-bit opcode and a 16-bit immediate. When the opcode is 12, the immediate packs one limit for each class. Each limit is the number of operations in that class that may still be unfinished when the wait ends. An all-ones limit tells the block to skip that class. The block raises `stall` while any class has more outstanding operations than its limit. It drops `stall` as soon as all three classes meet their limits together.

The counts are visible on output ports, so a sequencer can observe progress.

Top module: `opwait_tracker`

## Requirements
- R1: When `rst_n` is low, all three counts are 0 and `stall` is 0.
- R2: An issue pulse without a completion pulse raises that class's count by one at the next clock edge. A completion pulse without an issue pulse lowers it by one. An issue pulse and a completion pulse in the same cycle leave the count unchanged.
- R3: A count already at full scale (all ones) does not change on an issue pulse. A count at 0 does not change on a completion pulse.
- R4: A request is accepted when `req_valid` is 1, `req_op` equals 12 and `stall` is 0. If any count, taken after that cycle's update, exceeds its limit, `stall` is 1 from the next clock edge.
- R5: The vector-memory limit is `req_imm[3:0]`. The export-write limit is `req_imm[6:4]`. The local/global/constant limit is `req_imm[12:8]`. Bits 7 and 15:13 have no effect.
- R6: A vector-memory limit of 4'hF, an export limit of 3'h7, or a local/global/constant limit of 5'h1F means that class never holds the stall, even when its count is at full scale.
- R7: While stalled, `stall` stays 1 as long as any count is above its limit. It goes to 0 at the clock edge where all three counts are at or below their limits at the same time.
- R8: A request whose `req_op` is not 12 has no effect.
- R9: A request made while `stall` is 1 is ignored. The limits already in force stay in force.
- R10: If an accepted request's limits are already met by the counts after that cycle's update, including completions in the same cycle, `stall` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vm_issue | input | 1 | Vector-memory operation issued |
| vm_done | input | 1 | Vector-memory operation completed |
| ex_issue | input | 1 | Export write issued |
| ex_done | input | 1 | Export write completed |
| lg_issue | input | 1 | Local/global/constant memory operation issued |
| lg_done | input | 1 | Local/global/constant memory operation completed |
| req_valid | input | 1 | Wait request strobe |
| req_op | input | 7 | Opcode of the request (12 = wait) |
| req_imm | input | 16 | Packed limits |
| stall | output | 1 | High while the active wait is unmet |
| vm_count | output | VM_W | Outstanding vector-memory operations |
| ex_count | output | EX_W | Outstanding export writes |
| lg_count | output | LG_W | Outstanding local/global/constant operations |

## Verification
The bench builds the block with the default counter widths of 4, 3 and 5 bits. These match the limit fields, so full-scale saturation is reached after 15, 7 and 31 issues. At those widths the all-ones skip codes coincide with the largest possible count, which lets a wait at full scale show that a skipped class is never compared. The vector table covers same-cycle issue and completion, a request that is already satisfied, ignored requests, and the release of a stall by the last completion.

// File: rtl/opwait_tracker.sv
module opwait_tracker #(
  parameter int VM_W   = 4,
  parameter int EX_W   = 3,
  parameter int LG_W   = 5,
  parameter int OP_W   = 7,
  parameter int WAIT_OP = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vm_issue,
  input  logic            vm_done,
  input  logic            ex_issue,
  input  logic            ex_done,
  input  logic            lg_issue,
  input  logic            lg_done,
  input  logic            req_valid,
  input  logic [OP_W-1:0] req_op,
  input  logic [15:0]     req_imm,
  output logic            stall,
  output logic [VM_W-1:0] vm_count,
  output logic [EX_W-1:0] ex_count,
  output logic [LG_W-1:0] lg_count
);

  localparam logic [VM_W-1:0] VM_FULL = '1;
  localparam logic [EX_W-1:0] EX_FULL = '1;
  localparam logic [LG_W-1:0] LG_FULL = '1;

  logic [VM_W-1:0] vm_q, vm_n;
  logic [EX_W-1:0] ex_q, ex_n;
  logic [LG_W-1:0] lg_q, lg_n;
  logic [3:0] vm_lim_q, vm_lim;
  logic [2:0] ex_lim_q, ex_lim;
  logic [4:0] lg_lim_q, lg_lim;
  logic wait_q, accept, met;
  logic unused_imm;

  assign vm_n = (vm_issue && !vm_done && vm_q != VM_FULL) ? vm_q + 1'b1 :
                (vm_done && !vm_issue && vm_q != '0)      ? vm_q - 1'b1 : vm_q;
  assign ex_n = (ex_issue && !ex_done && ex_q != EX_FULL) ? ex_q + 1'b1 :
                (ex_done && !ex_issue && ex_q != '0)      ? ex_q - 1'b1 : ex_q;
  assign lg_n = (lg_issue && !lg_done && lg_q != LG_FULL) ? lg_q + 1'b1 :
                (lg_done && !lg_issue && lg_q != '0)      ? lg_q - 1'b1 : lg_q;

  assign accept = req_valid && (req_op == OP_W'(WAIT_OP)) && !wait_q;

  assign vm_lim = accept ? req_imm[3:0]  : vm_lim_q;
  assign ex_lim = accept ? req_imm[6:4]  : ex_lim_q;
  assign lg_lim = accept ? req_imm[12:8] : lg_lim_q;
  assign unused_imm = ^{req_imm[15:13], req_imm[7]};

  assign met = (vm_lim == 4'hF || 32'(vm_n) <= 32'(vm_lim)) &&
               (ex_lim == 3'h7 || 32'(ex_n) <= 32'(ex_lim)) &&
               (lg_lim == 5'h1F || 32'(lg_n) <= 32'(lg_lim));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vm_q <= '0;
      ex_q <= '0;
      lg_q <= '0;
    end else begin
      vm_q <= vm_n;
      ex_q <= ex_n;
      lg_q <= lg_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vm_lim_q <= 4'hF;
      ex_lim_q <= 3'h7;
      lg_lim_q <= 5'h1F;
      wait_q   <= 1'b0;
    end else begin
      if (accept) begin
        vm_lim_q <= req_imm[3:0];
        ex_lim_q <= req_imm[6:4];
        lg_lim_q <= req_imm[12:8];
      end
      wait_q <= (accept || wait_q) && !met;
    end
  end

  assign stall    = wait_q;
  assign vm_count = vm_q;
  assign ex_count = ex_q;
  assign lg_count = lg_q;

endmodule

// File: rtl/opwait_tracker_chk.sv
module opwait_tracker_chk #(
  parameter int VM_W = 4,
  parameter int EX_W = 3,
  parameter int LG_W = 5,
  parameter int OP_W = 7,
  parameter int WAIT_OP = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            vm_issue,
  input logic            vm_done,
  input logic            req_valid,
  input logic [OP_W-1:0] req_op,
  input logic            stall,
  input logic [VM_W-1:0] vm_count,
  input logic [EX_W-1:0] ex_count,
  input logic [LG_W-1:0] lg_count,
  input logic [3:0]      vm_lim_q,
  input logic [2:0]      ex_lim_q,
  input logic [4:0]      lg_lim_q
);

  p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vm_issue && !vm_done && vm_count != '1 |=> vm_count == $past(vm_count) + 1'b1);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vm_issue && vm_done |=> $stable(vm_count));

  p_sat_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vm_issue && !vm_done && vm_count == '1 |=> vm_count == '1);

  p_sat_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vm_done && !vm_issue && vm_count == '0 |=> vm_count == '0);

  p_stall_unmet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> ((vm_lim_q != 4'hF && 32'(vm_count) > 32'(vm_lim_q)) ||
               (ex_lim_q != 3'h7 && 32'(ex_count) > 32'(ex_lim_q)) ||
               (lg_lim_q != 5'h1F && 32'(lg_count) > 32'(lg_lim_q))));

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall && req_valid |=> $stable(vm_lim_q) && $stable(ex_lim_q) && $stable(lg_lim_q));

  p_foreign_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !stall && req_valid && req_op != OP_W'(WAIT_OP) |=> !stall);

endmodule

bind opwait_tracker opwait_tracker_chk #(
  .VM_W(VM_W), .EX_W(EX_W), .LG_W(LG_W), .OP_W(OP_W), .WAIT_OP(WAIT_OP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .vm_issue(vm_issue), .vm_done(vm_done),
  .req_valid(req_valid), .req_op(req_op), .stall(stall),
  .vm_count(vm_count), .ex_count(ex_count), .lg_count(lg_count),
  .vm_lim_q(vm_lim_q), .ex_lim_q(ex_lim_q), .lg_lim_q(lg_lim_q)
);

// File: tb/opwait_tracker_bench.sv
module opwait_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  // {pulses vi,vd,ei,ed,li,ld[6], req[1], op[7], imm[16], vm[4], ex[3], lg[5], stall[1]}
  localparam logic [42:0] VEC [NV] = '{
    {6'b101010, 1'b0, 7'd0,  16'h0000, 4'd1, 3'd1, 5'd1, 1'b0},  // R2
    {6'b101010, 1'b0, 7'd0,  16'h0000, 4'd2, 3'd2, 5'd2, 1'b0},  // R2
    {6'b100000, 1'b0, 7'd0,  16'h0000, 4'd3, 3'd2, 5'd2, 1'b0},  // R2
    {6'b110000, 1'b0, 7'd0,  16'h0000, 4'd3, 3'd2, 5'd2, 1'b0},  // R2 same cycle
    {6'b000000, 1'b1, 7'd12, 16'h1F71, 4'd3, 3'd2, 5'd2, 1'b1},  // R4 R5
    {6'b010000, 1'b0, 7'd0,  16'h0000, 4'd2, 3'd2, 5'd2, 1'b1},  // R7
    {6'b000000, 1'b1, 7'd12, 16'h0000, 4'd2, 3'd2, 5'd2, 1'b1},  // R9
    {6'b010000, 1'b0, 7'd0,  16'h0000, 4'd1, 3'd2, 5'd2, 1'b0},  // R7 R9
    {6'b000000, 1'b1, 7'd13, 16'h0000, 4'd1, 3'd2, 5'd2, 1'b0},  // R8
    {6'b000000, 1'b1, 7'd12, 16'h1F1F, 4'd1, 3'd2, 5'd2, 1'b1},  // R5 R6
    {6'b000100, 1'b0, 7'd0,  16'h0000, 4'd1, 3'd1, 5'd2, 1'b0},  // R7
    {6'b000000, 1'b1, 7'd12, 16'hE0FF, 4'd1, 3'd1, 5'd2, 1'b1},  // R5 ignored bits
    {6'b000001, 1'b0, 7'd0,  16'h0000, 4'd1, 3'd1, 5'd1, 1'b1},  // R7
    {6'b000011, 1'b0, 7'd0,  16'h0000, 4'd1, 3'd1, 5'd1, 1'b1},  // R2
    {6'b000001, 1'b0, 7'd0,  16'h0000, 4'd1, 3'd1, 5'd0, 1'b0},  // R7
    {6'b010100, 1'b1, 7'd12, 16'h0000, 4'd0, 3'd0, 5'd0, 1'b0},  // R10
    {6'b000000, 1'b1, 7'd12, 16'h0000, 4'd0, 3'd0, 5'd0, 1'b0},  // R10
    {6'b010101, 1'b0, 7'd0,  16'h0000, 4'd0, 3'd0, 5'd0, 1'b0}   // R3 floor
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vm_issue = 0, vm_done = 0, ex_issue = 0, ex_done = 0, lg_issue = 0, lg_done = 0;
  logic req_valid = 0;
  logic [6:0] req_op = '0;
  logic [15:0] req_imm = '0;
  logic stall;
  logic [3:0] vm_count;
  logic [2:0] ex_count;
  logic [4:0] lg_count;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opwait_tracker u_opwait_tracker (
    .clk(clk), .rst_n(rst_n),
    .vm_issue(vm_issue), .vm_done(vm_done), .ex_issue(ex_issue), .ex_done(ex_done),
    .lg_issue(lg_issue), .lg_done(lg_done),
    .req_valid(req_valid), .req_op(req_op), .req_imm(req_imm),
    .stall(stall), .vm_count(vm_count), .ex_count(ex_count), .lg_count(lg_count)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    {vm_issue, vm_done, ex_issue, ex_done, lg_issue, lg_done} = '0;
    req_valid = 0; req_op = '0; req_imm = '0;
  endtask

  task automatic request(logic [15:0] imm);
    req_valid = 1; req_op = 7'd12; req_imm = imm;
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    chk("R1 vm reset", vm_count, 0);
    chk("R1 ex reset", ex_count, 0);
    chk("R1 lg reset", lg_count, 0);
    chk("R1 stall reset", stall, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [42:0] v;
      v = VEC[i];
      {vm_issue, vm_done, ex_issue, ex_done, lg_issue, lg_done} = v[42:37];
      req_valid = v[36]; req_op = v[35:29]; req_imm = v[28:13];
      @(negedge clk);
      idle();
      chk($sformatf("vec%0d vm (R2 R3)", i), vm_count, int'(v[12:9]));
      chk($sformatf("vec%0d ex (R2 R3)", i), ex_count, int'(v[8:6]));
      chk($sformatf("vec%0d lg (R2 R3)", i), lg_count, int'(v[5:1]));
      chk($sformatf("vec%0d stall (R4 R5 R7 R8 R9 R10)", i), stall, int'(v[0]));
    end

    // R3: saturation at full scale
    vm_issue = 1; ex_issue = 1; lg_issue = 1;
    repeat (40) @(negedge clk);
    idle();
    chk("R3 vm full", vm_count, 15);
    chk("R3 ex full", ex_count, 7);
    chk("R3 lg full", lg_count, 31);

    // R6: all skip codes at full scale never stall
    request(16'h1F7F);
    chk("R6 skip all", stall, 0);
    @(negedge clk);
    chk("R6 skip all later", stall, 0);

    // R4 R7: vm limit 14, others skipped
    request(16'h1F7E);
    chk("R4 stall raised", stall, 1);
    vm_done = 1;
    @(negedge clk);
    idle();
    chk("R7 released", stall, 0);
    chk("R7 vm count", vm_count, 14);

    // R1: reset mid-run
    request(16'h0000);
    chk("R4 stall before reset", stall, 1);
    rst_n = 0;
    #1;
    chk("R1 async vm", vm_count, 0);
    chk("R1 async stall", stall, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset lg", lg_count, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule